// File: doc/BRIEF.md
# GCR Sector Address Header Detector

This block sits behind the bit-level read logic of a floppy disk controller. It watches the stream of 8-bit disk nibbles, each marked by a one-cycle valid strobe, and picks out a sector address header. A header is a three-nibble opening sequence, four bytes sent as odd/even nibble pairs, and one closing nibble. A one-cycle start request arms a search. The search ends with exactly one result pulse: either a valid pulse with the decoded volume, track, sector and checksum bytes, or an error pulse with a code that gives the reason.

The search is bounded. A counter preset near the top of its range advances on every nibble examined while the opening sequence is sought. If it wraps before the sequence is complete, the search gives up with a timeout. The decoded volume output is meant to be latched by the surrounding controller as the per-drive volume/geometry value when the valid pulse fires. Retry and recalibration decisions stay with the caller. The caller only has to raise start again.

Top module: `gcr_addr_detect`

## Requirements
- R1: After start, the opening sequence is the nibbles 0xD5, 0xAA, 0x96 received consecutively. Field decoding begins only with the nibble after the 0x96.
- R2: If the second or third nibble of the opening sequence does not match, that same nibble is tested as a possible first mark 0xD5. A stream such as D5 D5 AA 96 or D5 AA D5 AA 96 is therefore detected.
- R3: Each field byte comes from two nibbles. The first nibble, rotated left with a 1 shifted into bit 0, is ANDed with the second. The four bytes arrive in the order volume, track, sector, checksum. A byte b is carried by the nibbles (b>>1)|0xAA and then b|0xAA.
- R4: If the XOR of the four decoded bytes is not zero, hdr_err pulses in the cycle after the eighth field nibble with err_kind = 2, and the trailer is not waited for.
- R5: The nibble after the eighth field nibble must be 0xDE. Any other value gives an hdr_err pulse with err_kind = 3.
- R6: The nibbles received while the opening sequence is sought are counted. The 772nd such nibble after start gives an hdr_err pulse with err_kind = 1, whatever its value. A sequence completed by the 771st nibble is still accepted.
- R7: On a valid header, hdr_valid pulses for one cycle, one cycle after the 0xDE nibble is accepted. The volume, track, sector and cksum outputs take the decoded bytes in that same cycle.
- R8: volume, track, sector and cksum change only on a valid header. Errors leave them at their last good values. err_kind holds the code of the last error.
- R9: hdr_valid and hdr_err are never high together. Each armed search ends with at most one pulse lasting one cycle.
- R10: start re-arms the search from any state, including mid-header, and restarts the nibble count. A nibble strobed in the same cycle as start is ignored.
- R11: Nibbles received when no search is armed have no effect on any output.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to arm a new search |
| nib_valid | input | 1 | Strobe: nib holds a received nibble this cycle |
| nib | input | 8 | Received disk nibble |
| hdr_valid | output | 1 | One-cycle pulse: header decoded correctly |
| hdr_err | output | 1 | One-cycle pulse: search failed |
| err_kind | output | 2 | Last failure: 1 timeout, 2 checksum, 3 trailer |
| volume | output | 8 | Last good volume byte, for per-drive storage |
| track | output | 8 | Last good track byte |
| sector | output | 8 | Last good sector byte |
| cksum | output | 8 | Last good checksum byte |

## Verification
The hardest case to reach is the edge of the search window. A timeout needs hundreds of non-mark nibbles, and the nibble that makes the difference between success and timeout is one exact nibble out of 772. The stimulus therefore uses counted runs of filler nibbles. With 768 filler nibbles the opening sequence ends on the 771st nibble and must be accepted. With 769 filler nibbles the final 0x96 lands on the 772nd nibble and must time out. With 771 filler nibbles the 772nd nibble is a plain filler nibble and must also time out. The restart-clears-count behaviour is shown by two runs of 700 filler nibbles separated by a start. That stream only succeeds if the count really restarts.

// File: rtl/gcr_addr_pkg.sv
package gcr_addr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HUNT  = 3'd1,
    ST_GOT1  = 3'd2,
    ST_GOT2  = 3'd3,
    ST_FIELD = 3'd4,
    ST_TRAIL = 3'd5
  } seek_state_e;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_TIMEOUT = 2'd1,
    FAULT_CKSUM   = 2'd2,
    FAULT_TRAIL   = 2'd3
  } fault_e;

endpackage

// File: rtl/gcr_search_window.sv
module gcr_search_window #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CNT_INIT = 32'h0000_FCFC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);
  localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear | step;
    cnt_d  = clear ? INIT_V : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Wrap on this nibble means the window is used up.
  assign expire = step & ~clear & (cnt_q == TOP_V);

endmodule

// File: rtl/gcr_field_collect.sv
module gcr_field_collect #(
  parameter int unsigned NUM_FIELDS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic [7:0]              nib,
  output logic [NUM_FIELDS*8-1:0] fields,
  output logic                    last,
  output logic                    sum_zero
);
  localparam int unsigned NIBS  = 2 * NUM_FIELDS;
  localparam int unsigned IDX_W = $clog2(NIBS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       half_q, half_d;
  logic [7:0]       sum_q, sum_d;
  logic [7:0]       cur_byte;
  logic             odd_phase;
  logic [7:0]       stage_q [NUM_FIELDS];
  logic [7:0]       stage_d [NUM_FIELDS];

  always_comb begin
    odd_phase = idx_q[0];
    cur_byte  = half_q & nib;
    idx_d     = idx_q;
    half_d    = half_q;
    sum_d     = sum_q;
    for (int k = 0; k < NUM_FIELDS; k++) stage_d[k] = stage_q[k];
    if (clear) begin
      idx_d = '0;
      sum_d = '0;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      if (!odd_phase) begin
        half_d = {nib[6:0], 1'b1};
      end else begin
        sum_d = sum_q ^ cur_byte;
        stage_d[idx_q[IDX_W-1:1]] = cur_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      half_q <= '0;
      sum_q  <= '0;
      for (int k = 0; k < NUM_FIELDS; k++) stage_q[k] <= '0;
    end else if (clear | step) begin
      idx_q  <= idx_d;
      half_q <= half_d;
      sum_q  <= sum_d;
      for (int k = 0; k < NUM_FIELDS; k++) stage_q[k] <= stage_d[k];
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_flat
    if (g == NUM_FIELDS - 1) begin : g_tail
      // The final byte is still being formed on the deciding nibble.
      assign fields[g*8 +: 8] = (last) ? cur_byte : stage_q[g];
    end else begin : g_body
      assign fields[g*8 +: 8] = stage_q[g];
    end
  end

  assign last     = step & ~clear & odd_phase & (idx_q == LAST_IDX);
  assign sum_zero = ((sum_q ^ cur_byte) == 8'h00);

  // R3: a byte is stored only on the second nibble of a pair
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !idx_q[0]) |=> (idx_q[0] && half_q[0]));

endmodule

// File: rtl/gcr_addr_detect.sv
module gcr_addr_detect
  import gcr_addr_pkg::*;
#(
  parameter logic [7:0]  MARK1    = 8'hD5,
  parameter logic [7:0]  MARK2    = 8'hAA,
  parameter logic [7:0]  MARK3    = 8'h96,
  parameter logic [7:0]  TRAILER  = 8'hDE,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CNT_INIT = 32'h0000_FCFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       nib_valid,
  input  logic [7:0] nib,
  output logic       hdr_valid,
  output logic       hdr_err,
  output logic [1:0] err_kind,
  output logic [7:0] volume,
  output logic [7:0] track,
  output logic [7:0] sector,
  output logic [7:0] cksum
);
  localparam int unsigned NUM_FIELDS = 4;

  seek_state_e state_q, state_d;
  fault_e      kind_q, kind_d;
  logic        ok_d, err_d, ok_q, err_q;
  logic        win_step, win_expire, fld_step, fld_last, fld_sum_zero;
  logic [NUM_FIELDS*8-1:0] fld_bytes;
  logic [NUM_FIELDS*8-1:0] held_q;
  logic        searching;

  gcr_search_window #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(win_step),
    .expire(win_expire)
  );

  gcr_field_collect #(.NUM_FIELDS(NUM_FIELDS)) u_fields (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(fld_step), .nib(nib),
    .fields(fld_bytes), .last(fld_last), .sum_zero(fld_sum_zero)
  );

  always_comb begin
    searching = (state_q == ST_HUNT) || (state_q == ST_GOT1) ||
                (state_q == ST_GOT2);
    state_d  = state_q;
    kind_d   = kind_q;
    ok_d     = 1'b0;
    err_d    = 1'b0;
    win_step = 1'b0;
    fld_step = 1'b0;
    if (start) begin
      state_d = ST_HUNT;
    end else if (nib_valid) begin
      if (searching) begin
        win_step = 1'b1;
        if (win_expire) begin
          err_d   = 1'b1;
          kind_d  = FAULT_TIMEOUT;
          state_d = ST_IDLE;
        end else if (nib == MARK1) begin
          state_d = ST_GOT1;
        end else if (state_q == ST_GOT1 && nib == MARK2) begin
          state_d = ST_GOT2;
        end else if (state_q == ST_GOT2 && nib == MARK3) begin
          state_d = ST_FIELD;
        end else begin
          state_d = ST_HUNT;
        end
      end else if (state_q == ST_FIELD) begin
        fld_step = 1'b1;
        if (fld_last) begin
          if (fld_sum_zero) begin
            state_d = ST_TRAIL;
          end else begin
            err_d   = 1'b1;
            kind_d  = FAULT_CKSUM;
            state_d = ST_IDLE;
          end
        end
      end else if (state_q == ST_TRAIL) begin
        state_d = ST_IDLE;
        if (nib == TRAILER) begin
          ok_d = 1'b1;
        end else begin
          err_d  = 1'b1;
          kind_d = FAULT_TRAIL;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= FAULT_NONE;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (ok_d) held_q <= fld_bytes;
  end

  assign hdr_valid = ok_q;
  assign hdr_err   = err_q;
  assign err_kind  = kind_q;
  assign volume    = held_q[7:0];
  assign track     = held_q[15:8];
  assign sector    = held_q[23:16];
  assign cksum     = held_q[31:24];

  // R9
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_valid && hdr_err));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid || hdr_err) |=> !(hdr_valid || hdr_err));

  // R8
  hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $stable({volume, track, sector, cksum}));

  // R4
  valid_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> ((volume ^ track ^ sector ^ cksum) == 8'h00));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> !(hdr_valid || hdr_err));

  // R6
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_err && err_kind == FAULT_TIMEOUT) |-> $past(searching));

endmodule

// File: tb/sim_gcr_addr_detect.sv
`timescale 1ns/1ps
module sim_gcr_addr_detect;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, start, nib_valid;
  logic [7:0] nib;
  logic       hdr_valid, hdr_err;
  logic [1:0] err_kind;
  logic [7:0] volume, track, sector, cksum;

  gcr_addr_detect u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .nib_valid(nib_valid),
    .nib(nib), .hdr_valid(hdr_valid), .hdr_err(hdr_err),
    .err_kind(err_kind), .volume(volume), .track(track),
    .sector(sector), .cksum(cksum)
  );

  int n_chk = 0, n_bad = 0, n_val = 0, n_err = 0;

  always @(posedge clk) if (rst_n) begin
    if (hdr_valid) n_val++;
    if (hdr_err)   n_err++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] enc_a(logic [7:0] b); return (b >> 1) | 8'hAA; endfunction
  function automatic logic [7:0] enc_b(logic [7:0] b); return b | 8'hAA; endfunction

  task automatic send_nib(logic [7:0] b);
    @(negedge clk); nib = b; nib_valid = 1'b1;
    @(negedge clk); nib_valid = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic filler(int n);
    for (int i = 0; i < n; i++) send_nib(8'hFF);
  endtask

  task automatic send_fields(logic [7:0] v, t, s, c);
    send_nib(enc_a(v)); send_nib(enc_b(v));
    send_nib(enc_a(t)); send_nib(enc_b(t));
    send_nib(enc_a(s)); send_nib(enc_b(s));
    send_nib(enc_a(c)); send_nib(enc_b(c));
  endtask

  task automatic send_hdr(logic [7:0] v, t, s, c, tr);
    send_nib(8'hD5); send_nib(8'hAA); send_nib(8'h96);
    send_fields(v, t, s, c);
    send_nib(tr);
  endtask

  task automatic expect_ok(string tag, logic [7:0] v, t, s);
    int v0 = n_val, e0 = n_err;
    send_hdr(v, t, s, v ^ t ^ s, 8'hDE);
    chk(tag, "valid pulse", hdr_valid, 1);
    chk(tag, "volume", volume, v);
    chk(tag, "track", track, t);
    chk(tag, "sector", sector, s);
    chk(tag, "cksum", cksum, v ^ t ^ s);
    @(negedge clk);
    chk(tag, "valid ends", hdr_valid, 0);
    chk(tag, "one valid", n_val - v0, 1);
    chk(tag, "no error", n_err - e0, 0);
  endtask

  task automatic t_reset();
    chk("R12", "valid", hdr_valid, 0);
    chk("R12", "err", hdr_err, 0);
    chk("R12", "kind", err_kind, 0);
    chk("R12", "fields", {volume, track, sector, cksum}, 0);
  endtask

  task automatic t_idle_ignored();
    send_hdr(8'h12, 8'h34, 8'h56, 8'h12 ^ 8'h34 ^ 8'h56, 8'hDE);
    @(negedge clk);
    chk("R11", "pulses", n_val + n_err, 0);
    chk("R11", "volume", volume, 0);
  endtask

  task automatic t_basic();
    do_start();
    filler(5);
    expect_ok("R1", 8'hFE, 8'h22, 8'h0F);
    do_start();
    expect_ok("R3", 8'h01, 8'h80, 8'h5A);
    do_start();
    expect_ok("R7", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_resync();
    do_start();
    send_nib(8'hD5);
    expect_ok("R2", 8'h33, 8'h11, 8'h07);
    do_start();
    send_nib(8'hD5); send_nib(8'hAA);
    expect_ok("R2", 8'h44, 8'h12, 8'h0A);
    do_start();
    send_nib(8'hD5); send_nib(8'hAA); send_nib(8'hAA); send_nib(8'h96);
    send_fields(8'h99, 8'h99, 8'h99, 8'h99);
    send_nib(8'hDE);
    expect_ok("R1", 8'h55, 8'h21, 8'h03);
  endtask

  task automatic t_bad_sum();
    int e0 = n_err;
    do_start();
    send_nib(8'hD5); send_nib(8'hAA); send_nib(8'h96);
    send_fields(8'h10, 8'h20, 8'h30, 8'h41);
    chk("R4", "err pulse", hdr_err, 1);
    chk("R4", "kind", err_kind, 2);
    chk("R8", "volume held", volume, 8'h55);
    chk("R8", "track held", track, 8'h21);
    send_nib(8'hDE);
    @(negedge clk);
    chk("R9", "one error", n_err - e0, 1);
    chk("R4", "no valid", hdr_valid, 0);
  endtask

  task automatic t_bad_trailer();
    int v0 = n_val;
    do_start();
    send_hdr(8'h10, 8'h20, 8'h30, 8'h10 ^ 8'h20 ^ 8'h30, 8'hEB);
    chk("R5", "err pulse", hdr_err, 1);
    chk("R5", "kind", err_kind, 3);
    chk("R8", "sector held", sector, 8'h03);
    @(negedge clk);
    chk("R5", "no valid", n_val - v0, 0);
  endtask

  task automatic t_timeout();
    int e0 = n_err;
    do_start();
    filler(771);
    chk("R6", "no err at 771", n_err - e0, 0);
    send_nib(8'hFF);
    chk("R6", "err at 772", hdr_err, 1);
    chk("R6", "kind", err_kind, 1);
    do_start();
    filler(769);
    send_nib(8'hD5); send_nib(8'hAA); send_nib(8'h96);
    chk("R6", "mark on 772", hdr_err, 1);
    chk("R6", "kind late", err_kind, 1);
    do_start();
    filler(768);
    expect_ok("R6", 8'h6C, 8'h23, 8'h09);
  endtask

  task automatic t_restart();
    int e0;
    do_start();
    filler(700);
    do_start();
    filler(700);
    e0 = n_err;
    expect_ok("R10", 8'h77, 8'h05, 8'h0B);
    chk("R10", "no timeout", n_err - e0, 0);
    do_start();
    send_nib(8'hD5); send_nib(8'hAA); send_nib(8'h96);
    send_nib(enc_a(8'hAB)); send_nib(enc_b(8'hAB)); send_nib(enc_a(8'hCD));
    do_start();
    expect_ok("R10", 8'h3C, 8'h19, 8'h0E);
    // nibble strobed with start is dropped
    @(negedge clk); start = 1'b1; nib = 8'hD5; nib_valid = 1'b1;
    @(negedge clk); start = 1'b0; nib_valid = 1'b0;
    send_nib(8'hAA); send_nib(8'h96);
    send_fields(8'h11, 8'h22, 8'h33, 8'h00);
    send_nib(8'hDE);
    @(negedge clk);
    chk("R10", "start nibble dropped", volume, 8'h3C);
    expect_ok("R10", 8'h5E, 8'h0C, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; nib_valid = 1'b0; nib = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_basic();
    t_resync();
    t_bad_sum();
    t_bad_trailer();
    t_timeout();
    t_restart();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule